// File: doc/BRIEF.md
# Serial Management Byte-Register Slave

This block is a slave on a two-wire management bus made of a clock (MDC) and a bidirectional data line (MDIO). It samples MDIO on every rising MDC edge and parses each frame into its parts: a run of preamble ones, a start pair, a two-bit opcode, a five-bit PHY address, a five-bit register address and a turnaround pair. It then either takes in sixteen data bits or returns sixteen data bits through an output enable that controls an external tristate buffer. The register store holds 256 bytes.

Only frames whose PHY address has bits [2:1] equal to 11 reach the register store. In those frames, the other three PHY-address bits sit above the five register-address bits and together they form an 8-bit byte index. The sixteen-bit data field of the bus carries one byte. Reads fill the upper half with zeros. Writes throw the upper half away. Frames with any other PHY address pass by with no effect.

Top module: `mdio_regbank_slave`

## Requirements
- R1: The block accepts a frame only after it has seen at least 32 consecutive 1 bits followed by the start pair 0 then 1. With 31 ones before the start pair, the frame does not drive MDIO and does not write.
- R2: When the PHY address bits [2:1] are not 11, the frame is ignored. MDIO is not driven and no register changes.
- R3: Opcode 10 (first bit 1) selects a read and opcode 01 selects a write. Opcodes 00 and 11 abort the frame, and then nothing is driven and nothing is written.
- R4: The byte index is {PHY[4], PHY[3], PHY[0], REG[4:0]}, with PHY[4] as index bit 7. Address bits are sent most significant bit first.
- R5: In a read, MDIO stays undriven (mdio_oe low) for the first turnaround bit. The block then drives 0 for the second turnaround bit.
- R6: In a read, the sixteen data bits are {8'h00, stored byte}, most significant bit first. Each bit changes after a rising MDC edge so that the master can sample it on the next rising edge.
- R7: In a write, data bits [15:8] are discarded and bits [7:0] are stored at the index. The store is updated one MDC cycle after the sixteenth data bit is sampled, and the update lasts a single cycle.
- R8: mdio_oe drops after data bit 0 has been presented, so the output enable is high for exactly 17 cycles per read. It stays low whenever the block is idle or in reset.
- R9: Reset clears all 256 bytes to zero.
- R10: Every index from 0x00 to 0xFF can be written and read back on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdio_in | input | 1 | Value on the MDIO line as seen by the slave |
| mdio_out | output | 1 | Data the slave puts on MDIO while enabled |
| mdio_oe | output | 1 | Tristate enable for mdio_out; high means the slave drives the line |

## Verification
The checker assumes that the master changes MDIO only between rising edges, that it releases the line before the first turnaround bit of a read, and that it does not drive the line while the slave does. A pull-up is assumed, so the released line reads as 1. The bench master changes its output only on falling edges and releases the line at the first turnaround bit of every read. Its model of the line resolves the enable, the master's drive and the pull-up in that order of priority, so both sides never drive at once. Every frame begins with a single 0 bit so that the idle ones between frames cannot lengthen a preamble that is deliberately short.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int OP_W   = 2;
  localparam int HDR_W  = OP_W + PHY_W + REG_W;
  localparam int IDX_W  = 3 + REG_W;

  localparam logic [OP_W-1:0] OP_RD = 2'b10;
  localparam logic [OP_W-1:0] OP_WR = 2'b01;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_HDR,
    ST_TA,
    ST_DATA
  } mdio_st_e;

  function automatic logic sel_hit_f(input logic [PHY_W-1:0] phy);
    return phy[2:1] == 2'b11;
  endfunction

  function automatic logic [IDX_W-1:0] reg_index_f(input logic [PHY_W-1:0] phy,
                                                   input logic [REG_W-1:0] ra);
    return {phy[4], phy[3], phy[0], ra};
  endfunction

  function automatic logic op_valid_f(input logic [OP_W-1:0] op);
    return (op == OP_RD) || (op == OP_WR);
  endfunction

endpackage

// File: rtl/mdio_frame_decoder.sv
module mdio_frame_decoder
  import mdio_slv_pkg::*;
#(
  parameter int PRE_MIN = 32,
  parameter int FIELD_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mdio_in,
  output logic             hdr_done,
  output logic             sel_hit,
  output logic             rd_frame,
  output logic [IDX_W-1:0] idx,
  output logic             tx_load,
  output logic             tx_shift,
  output logic             tx_release,
  output logic             wr_stb,
  output logic [IDX_W-1:0] wr_idx,
  output logic [BYTE_W-1:0] wr_byte
);

  localparam int PRE_W = $clog2(PRE_MIN + 1);
  localparam int CNT_W = $clog2(FIELD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FIELD_W - 1);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);

  mdio_st_e           state;
  logic [PRE_W-1:0]   pre_cnt;
  logic [CNT_W-1:0]   bit_cnt;
  logic [HDR_W-1:0]   hdr_sh;
  logic [BYTE_W-1:0]  wsh;

  logic [HDR_W-1:0]   hdr_nx;
  logic [PHY_W-1:0]   phy_w;
  logic [REG_W-1:0]   ra_w;
  logic [OP_W-1:0]    op_w;
  logic               op_check;
  logic               data_last;

  always_comb begin
    hdr_nx    = {hdr_sh[HDR_W-2:0], mdio_in};
    phy_w     = hdr_nx[REG_W +: PHY_W];
    ra_w      = hdr_nx[REG_W-1:0];
    op_w      = hdr_nx[HDR_W-1 -: OP_W];
    op_check  = (state == ST_HDR) && (bit_cnt == CNT_W'(OP_W - 1));
    hdr_done  = (state == ST_HDR) && (bit_cnt == HDR_LAST);
    sel_hit   = sel_hit_f(phy_w);
    data_last = (state == ST_DATA) && (bit_cnt == LAST_BIT);
    tx_load   = (state == ST_TA) && (bit_cnt == '0) && rd_frame;
    tx_shift  = rd_frame && (((state == ST_TA) && (bit_cnt != '0)) ||
                             ((state == ST_DATA) && !data_last));
    tx_release = rd_frame && data_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HUNT;
      pre_cnt  <= '0;
      bit_cnt  <= '0;
      hdr_sh   <= '0;
      wsh      <= '0;
      rd_frame <= 1'b0;
      idx      <= '0;
      wr_stb   <= 1'b0;
      wr_idx   <= '0;
      wr_byte  <= '0;
    end else begin
      wr_stb <= 1'b0;
      unique case (state)
        ST_HUNT: begin
          if (mdio_in) begin
            if (pre_cnt < PRE_W'(PRE_MIN)) pre_cnt <= pre_cnt + 1'b1;
          end else if (pre_cnt >= PRE_W'(PRE_MIN)) begin
            state   <= ST_START;
            pre_cnt <= '0;
          end else begin
            pre_cnt <= '0;
          end
        end
        ST_START: begin
          bit_cnt <= '0;
          state   <= mdio_in ? ST_HDR : ST_HUNT;
        end
        ST_HDR: begin
          hdr_sh  <= hdr_nx;
          bit_cnt <= bit_cnt + 1'b1;
          if (op_check && !op_valid_f(hdr_nx[OP_W-1:0])) begin
            state <= ST_HUNT;
          end else if (hdr_done) begin
            bit_cnt <= '0;
            if (sel_hit && op_valid_f(op_w)) begin
              state    <= ST_TA;
              rd_frame <= (op_w == OP_RD);
              idx      <= reg_index_f(phy_w, ra_w);
            end else begin
              state <= ST_HUNT;
            end
          end
        end
        ST_TA: begin
          if (bit_cnt != '0) begin
            state   <= ST_DATA;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_DATA: begin
          wsh     <= {wsh[BYTE_W-2:0], mdio_in};
          bit_cnt <= bit_cnt + 1'b1;
          if (data_last) begin
            state   <= ST_HUNT;
            pre_cnt <= '0;
            bit_cnt <= '0;
            if (!rd_frame) begin
              wr_stb  <= 1'b1;
              wr_idx  <= idx;
              wr_byte <= {wsh[BYTE_W-2:0], mdio_in};
            end
            rd_frame <= 1'b0;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/mdio_byte_bank.sv
module mdio_byte_bank #(
  parameter int IDX_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [BYTE_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mem[g] <= '0;
      else if (we && (widx == IDX_W'(g)))        mem[g] <= wdata;
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/mdio_tx_shifter.sv
module mdio_tx_shifter #(
  parameter int FIELD_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              release_line,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              mdio_out,
  output logic              mdio_oe
);

  logic [FIELD_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else if (load) begin
      sh       <= FIELD_W'(byte_in);
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b1;
    end else if (shift) begin
      mdio_out <= sh[FIELD_W-1];
      sh       <= {sh[FIELD_W-2:0], 1'b0};
    end else if (release_line) begin
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end
  end

endmodule

// File: rtl/mdio_regbank_slave.sv
module mdio_regbank_slave
  import mdio_slv_pkg::*;
#(
  parameter int PRE_MIN = 32,
  parameter int FIELD_W = 16,
  parameter int BYTE_W  = 8
) (
  input  logic mdc,
  input  logic rst_n,
  input  logic mdio_in,
  output logic mdio_out,
  output logic mdio_oe
);

  logic              hdr_done;
  logic              sel_hit;
  logic              rd_frame;
  logic [IDX_W-1:0]  idx;
  logic              tx_load;
  logic              tx_shift;
  logic              tx_release;
  logic              wr_stb;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_byte;
  logic [BYTE_W-1:0] rd_byte;

  mdio_frame_decoder #(
    .PRE_MIN(PRE_MIN), .FIELD_W(FIELD_W), .BYTE_W(BYTE_W)
  ) u_dec (
    .clk(mdc), .rst_n(rst_n), .mdio_in(mdio_in),
    .hdr_done(hdr_done), .sel_hit(sel_hit), .rd_frame(rd_frame), .idx(idx),
    .tx_load(tx_load), .tx_shift(tx_shift), .tx_release(tx_release),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_byte(wr_byte)
  );

  mdio_byte_bank #(
    .IDX_W(IDX_W), .BYTE_W(BYTE_W)
  ) u_bank (
    .clk(mdc), .rst_n(rst_n), .we(wr_stb), .widx(wr_idx), .wdata(wr_byte),
    .ridx(idx), .rdata(rd_byte)
  );

  mdio_tx_shifter #(
    .FIELD_W(FIELD_W), .BYTE_W(BYTE_W)
  ) u_tx (
    .clk(mdc), .rst_n(rst_n), .load(tx_load), .shift(tx_shift),
    .release_line(tx_release), .byte_in(rd_byte),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

endmodule

// File: rtl/mdio_regbank_checker.sv
module mdio_regbank_checker #(
  parameter int FIELD_W = 16,
  parameter int BYTE_W  = 8
) (
  input logic mdc,
  input logic rst_n,
  input logic mdio_oe,
  input logic mdio_out,
  input logic hdr_done,
  input logic sel_hit,
  input logic wr_stb
);

  localparam int OC_W = $clog2(FIELD_W + 2);

  logic [OC_W-1:0] oe_cnt;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n)       oe_cnt <= '0;
    else if (mdio_oe) oe_cnt <= oe_cnt + 1'b1;
    else              oe_cnt <= '0;
  end

  assert_ignore_nodrive_R2: assert property (@(posedge mdc) disable iff (!rst_n)
    (hdr_done && !sel_hit) |=> !mdio_oe);

  assert_ignore_nowrite_R2: assert property (@(posedge mdc) disable iff (!rst_n)
    (hdr_done && !sel_hit) |=> !wr_stb);

  assert_ta_float_R5: assert property (@(posedge mdc) disable iff (!rst_n)
    (hdr_done && sel_hit) |=> !mdio_oe);

  assert_ta_zero_R5: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);

  assert_upper_zero_R6: assert property (@(posedge mdc) disable iff (!rst_n)
    (mdio_oe && oe_cnt >= OC_W'(1) && oe_cnt <= OC_W'(BYTE_W)) |-> !mdio_out);

  assert_drive_len_R8: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (oe_cnt <= OC_W'(FIELD_W)));

  assert_release_R8: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> ($past(oe_cnt) == OC_W'(FIELD_W)));

  assert_commit_single_R7: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_commit_quiet_R7: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_stb |-> !mdio_oe);

endmodule

bind mdio_regbank_slave mdio_regbank_checker #(
  .FIELD_W(FIELD_W), .BYTE_W(BYTE_W)
) u_chk (
  .mdc(mdc), .rst_n(rst_n), .mdio_oe(mdio_oe), .mdio_out(mdio_out),
  .hdr_done(hdr_done), .sel_hit(sel_hit), .wr_stb(wr_stb)
);

// File: tb/mdio_regbank_slave_bench.sv
`timescale 1ns/1ps
module mdio_regbank_slave_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_oe = 1'b0;
  logic m_val = 1'b1;
  logic mdio_out, mdio_oe;
  logic line;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic oe_seen = 1'b0;
  logic [7:0] shadow [256];

  always #10 clk = ~clk;

  assign line = mdio_oe ? mdio_out : (m_oe ? m_val : 1'b1);

  mdio_regbank_slave u_mdio_regbank_slave (
    .mdc(clk), .rst_n(rst_n), .mdio_in(line),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  always @(negedge clk) if (mdio_oe) oe_seen = 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk);
    m_oe  = 1'b1;
    m_val = b;
  endtask

  // leading 0, pre_len ones, start 01, opcode, phy, reg (all MSB first)
  task automatic send_hdr(input int pre_len, input logic [1:0] op,
                          input logic [4:0] phy, input logic [4:0] ra);
    drive_bit(1'b0);
    for (int k = 0; k < pre_len; k++) drive_bit(1'b1);
    drive_bit(1'b0);
    drive_bit(1'b1);
    for (int k = 1; k >= 0; k--) drive_bit(op[k]);
    for (int k = 4; k >= 0; k--) drive_bit(phy[k]);
    for (int k = 4; k >= 0; k--) drive_bit(ra[k]);
  endtask

  task automatic do_write(input int pre_len, input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] ra, input logic [15:0] d);
    send_hdr(pre_len, op, phy, ra);
    drive_bit(1'b1);
    drive_bit(1'b0);
    for (int k = 15; k >= 0; k--) drive_bit(d[k]);
    @(negedge clk);
    m_oe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // returns sampled data, TA pattern ok flag, full-drive flag, release flag
  task automatic do_read(input logic [4:0] phy, input logic [4:0] ra,
                         output logic [15:0] d, output logic ta_ok,
                         output logic drv_ok, output logic rel_ok);
    send_hdr(32, 2'b10, phy, ra);
    @(negedge clk);
    m_oe  = 1'b0;
    ta_ok = !mdio_oe;
    @(negedge clk);
    ta_ok = ta_ok && mdio_oe && !mdio_out;
    drv_ok = 1'b1;
    for (int k = 15; k >= 0; k--) begin
      @(negedge clk);
      d[k]   = mdio_out;
      drv_ok = drv_ok && mdio_oe;
    end
    @(negedge clk);
    rel_ok = !mdio_oe;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 7) & 8'hFF);
  endfunction

  function automatic logic [4:0] phy_of(input int i);
    logic [7:0] a;
    a = 8'(i);
    return {a[7], a[6], 2'b11, a[5]};
  endfunction

  function automatic logic [4:0] reg_of(input int i);
    return 5'(i % 32);
  endfunction

  task automatic read_check(input int i, input string tag);
    logic [15:0] d;
    logic ta_ok, drv_ok, rel_ok;
    do_read(phy_of(i), reg_of(i), d, ta_ok, drv_ok, rel_ok);
    chk(d == {8'h00, shadow[i]} && drv_ok, tag, int'(d), int'({8'h00, shadow[i]}));
    chk(ta_ok && rel_ok, "R5_R8 turnaround/release", int'({ta_ok, rel_ok}), 3);
  endtask

  task automatic sweep_read(input string tag);
    for (int i = 0; i < 256; i++) read_check(i, tag);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!mdio_oe, "R8 idle in reset", int'(mdio_oe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mdio_oe, "R8 idle after reset", int'(mdio_oe), 0);

    // R9: all bytes zero after reset
    sweep_read("R9 reset value");

    // R4 R7 R10: write every index with garbage in upper byte
    for (int i = 0; i < 256; i++) begin
      shadow[i] = pat(i);
      do_write(32, 2'b01, phy_of(i), reg_of(i), {8'(8'hA5 ^ i), pat(i)});
    end
    sweep_read("R4_R6_R7_R10 readback");

    // R2: ignored PHY addresses, both write and read frames
    oe_seen = 1'b0;
    for (int p = 0; p < 32; p++) begin
      logic [4:0] ph;
      logic [15:0] d;
      logic a, b, c;
      ph = 5'(p);
      if (ph[2:1] != 2'b11) begin
        do_write(32, 2'b01, ph, 5'd5, 16'h005A);
        send_hdr(32, 2'b10, ph, 5'd5);
        @(negedge clk);
        m_oe = 1'b0;
        repeat (20) @(negedge clk);
      end
      d = 16'h0; a = 1'b0; b = 1'b0; c = 1'b0;
    end
    chk(!oe_seen, "R2 no drive on foreign PHY", int'(oe_seen), 0);
    sweep_read("R2 bank untouched");

    // R1: 31 preamble ones, write and read
    oe_seen = 1'b0;
    do_write(31, 2'b01, phy_of(3), reg_of(3), 16'h0000);
    send_hdr(31, 2'b10, phy_of(3), reg_of(3));
    @(negedge clk);
    m_oe = 1'b0;
    repeat (20) @(negedge clk);
    chk(!oe_seen, "R1 short preamble no drive", int'(oe_seen), 0);
    read_check(3, "R1 short preamble no write");

    // R3: invalid opcodes 00 and 11
    oe_seen = 1'b0;
    do_write(32, 2'b00, phy_of(9), reg_of(9), 16'h0000);
    do_write(32, 2'b11, phy_of(9), reg_of(9), 16'h0000);
    chk(!oe_seen, "R3 bad opcode no drive", int'(oe_seen), 0);
    read_check(9, "R3 bad opcode no write");

    // R1 R7: exact 32-bit preamble write, then back-to-back readback
    shadow[8'hFF] = 8'h3C;
    do_write(32, 2'b01, phy_of(255), reg_of(255), 16'hFF3C);
    read_check(255, "R1_R7 min preamble write");
    shadow[8'h00] = 8'hFF;
    do_write(32, 2'b01, phy_of(0), reg_of(0), 16'h00FF);
    read_check(0, "R6_R10 low corner");
    read_check(1, "R4 neighbour intact");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule